// File: doc/BRIEF.md
# Network MAC Event Statistics Counters with Half-Range Interrupts

This block keeps six event counters for a network MAC. Three of them track receive events: good unicast frames, frames with an alignment error and frames with a CRC error. The other three track transmit events: good frames, good frames sent after exactly one collision, and good frames sent after more than one collision. Each event arrives as a one-cycle pulse, and each pulse adds one to its counter.

Every counter has a status flag. The flag is raised when the counter's top bit goes from 0 to 1, which happens when the counter reaches half of its range. The receive flags and the transmit flags are gathered into two 32-bit status words. A flag stays set until software reads the low byte lane of the counter that raised it.

Each direction has a mask register and one registered interrupt line. The interrupt is raised when at least one status flag of that direction is set and its mask bit is clear.

Top module: `mac_stat_counters`

## Requirements
- R1: Each counter adds exactly one on every cycle in which its event pulse is high, and holds its value otherwise. The counters are independent of each other.
- R2: A flag sets on the clock edge at which its counter's most significant bit goes from 0 to 1. The flags sit at fixed bit positions:
  - Receive status word: bit 17 is good unicast, bit 6 is alignment error, bit 5 is CRC error.
  - Transmit status word: bit 21 is good frames, bit 14 is single collision, bit 15 is multiple collision.
  - Every other bit of both words reads 0.
- R3: A read clears the flag of the counter it selects, one edge later, when it includes byte lane 0. A read is rd_en high, with rd_sel selecting the counter and rd_lanes[0] high. The rd_sel codes are:
  - 0: receive good unicast
  - 1: receive alignment error
  - 2: receive CRC error
  - 3: transmit good
  - 4: transmit single collision
  - 5: transmit multiple collision
- R4: A read with rd_lanes[0] low leaves the flag set. A read that selects a different counter also leaves the flag set.
- R5: If a lane-0 read of a counter falls on the same edge as that counter's 0-to-1 MSB transition, the flag ends up set.
- R6: A counter goes from all ones to zero on its next event. Wrapping does not change the counter's flag.
- R7: After a clearing read, further events leave the flag clear as long as the counter's MSB stays 1.
- R8: A mask write stores mask_wdata into one direction's mask register. The write is mask_we high, with mask_sel 0 for receive and 1 for transmit. A mask bit of 1 keeps the status bit at the same position from raising that direction's interrupt. The status bit itself still sets.
- R9: Each interrupt output is registered. On every cycle it equals the value, one cycle earlier, of the OR over that direction's status bits ANDed with the inverted mask bits.
- R10: While rst_n is low, all of the following are zero: every counter, both status words, both masks and both interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_rx_ucast_ok | input | 1 | Pulse: good unicast frame received |
| ev_rx_align_err | input | 1 | Pulse: frame with alignment error received |
| ev_rx_crc_err | input | 1 | Pulse: frame with CRC error received |
| ev_tx_ok | input | 1 | Pulse: good frame sent |
| ev_tx_one_coll | input | 1 | Pulse: good frame sent after a single collision |
| ev_tx_multi_coll | input | 1 | Pulse: good frame sent after several collisions |
| rd_en | input | 1 | Counter read strobe |
| rd_sel | input | 3 | Counter selected by the read (codes listed in R3) |
| rd_lanes | input | 4 | Byte lanes covered by the read; bit 0 is bits [7:0] |
| mask_we | input | 1 | Mask write strobe |
| mask_sel | input | 1 | Mask register selected by the write: 0 receive, 1 transmit |
| mask_wdata | input | 32 | Mask write data |
| cnt_flat | output | 6*CNT_W | Counter values; counter k is in bits [k*CNT_W +: CNT_W] |
| rx_status | output | 32 | Receive status word |
| tx_status | output | 32 | Transmit status word |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The embedded properties are evaluated on every cycle and check four behaviours:
- The single-step counting rule.
- A flag may rise only on an MSB transition of its own counter.
- A flag may fall only after a lane-0 read of its own counter.
- The one-cycle relation between the masked status and each interrupt line.

Some cases can only be shown by the bench's scenarios, because they depend on chosen event orderings. These are a set colliding with a clearing read, upper-lane-only reads, events arriving after a clear while the MSB is still high, a wrap with the flag set, and masking. The bench runs the counters at a narrow width so that the half-range point is reachable.

// File: rtl/mac_stat_counters.sv
module mac_stat_counters #(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_rx_ucast_ok,
  input  logic                 ev_rx_align_err,
  input  logic                 ev_rx_crc_err,
  input  logic                 ev_tx_ok,
  input  logic                 ev_tx_one_coll,
  input  logic                 ev_tx_multi_coll,
  input  logic                 rd_en,
  input  logic [2:0]           rd_sel,
  input  logic [3:0]           rd_lanes,
  input  logic                 mask_we,
  input  logic                 mask_sel,
  input  logic [31:0]          mask_wdata,
  output logic [6*CNT_W-1:0]   cnt_flat,
  output logic [31:0]          rx_status,
  output logic [31:0]          tx_status,
  output logic                 rx_irq,
  output logic                 tx_irq
);
  localparam int NCNT = 6;
  localparam int MSB  = CNT_W - 1;

  logic [NCNT-1:0]  ev;
  logic [NCNT-1:0]  flag;
  logic [NCNT-1:0]  msb_rise;
  logic [NCNT-1:0]  rd_clr;
  logic [CNT_W-1:0] cnt [NCNT];
  logic [31:0]      rx_msk_q, tx_msk_q;

  assign ev = {ev_tx_multi_coll, ev_tx_one_coll, ev_tx_ok,
               ev_rx_crc_err, ev_rx_align_err, ev_rx_ucast_ok};

  for (genvar i = 0; i < NCNT; i++) begin : g_ctl
    logic [CNT_W-1:0] nxt;
    assign nxt         = cnt[i] + CNT_W'(ev[i]);
    assign msb_rise[i] = !cnt[i][MSB] && nxt[MSB];
    assign rd_clr[i]   = rd_en && (rd_sel == 3'(i)) && rd_lanes[0];
    assign cnt_flat[i*CNT_W +: CNT_W] = cnt[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCNT; i++) cnt[i] <= '0;
      flag <= '0;
    end else begin
      for (int i = 0; i < NCNT; i++) cnt[i] <= cnt[i] + CNT_W'(ev[i]);
      flag <= msb_rise | (flag & ~rd_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_msk_q <= '0;
      tx_msk_q <= '0;
    end else if (mask_we) begin
      if (mask_sel) tx_msk_q <= mask_wdata;
      else          rx_msk_q <= mask_wdata;
    end
  end

  always_comb begin
    rx_status     = '0;
    rx_status[17] = flag[0];
    rx_status[6]  = flag[1];
    rx_status[5]  = flag[2];
    tx_status     = '0;
    tx_status[21] = flag[3];
    tx_status[14] = flag[4];
    tx_status[15] = flag[5];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_irq <= 1'b0;
      tx_irq <= 1'b0;
    end else begin
      rx_irq <= |(rx_status & ~rx_msk_q);
      tx_irq <= |(tx_status & ~tx_msk_q);
    end
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_chk
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> cnt[i] == $past(cnt[i]) + CNT_W'($past(ev[i])));
    assert_rise_on_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> (cnt[i][MSB] && !$past(cnt[i][MSB])));
    assert_fall_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(rd_en && rd_sel == 3'(i) && rd_lanes[0]));
  end

  assert_rx_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rx_irq == $past(|(rx_status & ~rx_msk_q)));
  assert_tx_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tx_irq == $past(|(tx_status & ~tx_msk_q)));
endmodule

// File: tb/mac_stat_counters_tb_top.sv
module mac_stat_counters_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ev = '0;
  logic rd_en = 1'b0;
  logic [2:0] rd_sel = '0;
  logic [3:0] rd_lanes = '0;
  logic mask_we = 1'b0;
  logic mask_sel = 1'b0;
  logic [31:0] mask_wdata = '0;
  logic [6*W-1:0] cnt_flat;
  logic [31:0] rx_status, tx_status;
  logic rx_irq, tx_irq;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_cnt [6];
  logic [5:0]   m_flag;
  logic [31:0]  m_rxm, m_txm;
  logic         m_rxirq, m_txirq;

  always #(CLK_P/2) clk = ~clk;

  mac_stat_counters #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_ucast_ok(ev[0]), .ev_rx_align_err(ev[1]), .ev_rx_crc_err(ev[2]),
    .ev_tx_ok(ev[3]), .ev_tx_one_coll(ev[4]), .ev_tx_multi_coll(ev[5]),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_lanes(rd_lanes),
    .mask_we(mask_we), .mask_sel(mask_sel), .mask_wdata(mask_wdata),
    .cnt_flat(cnt_flat), .rx_status(rx_status), .tx_status(tx_status),
    .rx_irq(rx_irq), .tx_irq(tx_irq));

  function automatic logic [31:0] exp_rx(input logic [5:0] f);
    logic [31:0] s = '0;
    s[17] = f[0]; s[6] = f[1]; s[5] = f[2];
    return s;
  endfunction

  function automatic logic [31:0] exp_tx(input logic [5:0] f);
    logic [31:0] s = '0;
    s[21] = f[3]; s[14] = f[4]; s[15] = f[5];
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 6; i++) m_cnt[i] = '0;
    m_flag = '0; m_rxm = '0; m_txm = '0; m_rxirq = 0; m_txirq = 0;
  endtask

  task automatic compare_all();
    for (int i = 0; i < 6; i++)
      chk("R1/R6 counter", 32'(cnt_flat[i*W +: W]), 32'(m_cnt[i]));
    chk("R2/R3/R4/R5/R7 rx_status", rx_status, exp_rx(m_flag));
    chk("R2/R3/R4/R5/R7 tx_status", tx_status, exp_tx(m_flag));
    chk("R8/R9 rx_irq", 32'(rx_irq), 32'(m_rxirq));
    chk("R8/R9 tx_irq", 32'(tx_irq), 32'(m_txirq));
  endtask

  task automatic tick();
    logic [W-1:0] nc;
    logic rise, clr;
    @(posedge clk);
    m_rxirq = |(exp_rx(m_flag) & ~m_rxm);
    m_txirq = |(exp_tx(m_flag) & ~m_txm);
    for (int i = 0; i < 6; i++) begin
      nc   = m_cnt[i] + W'(ev[i]);
      rise = !m_cnt[i][W-1] && nc[W-1];
      clr  = rd_en && rd_sel == 3'(i) && rd_lanes[0];
      m_flag[i] = rise || (m_flag[i] && !clr);
      m_cnt[i]  = nc;
    end
    if (mask_we) begin
      if (mask_sel) m_txm = mask_wdata; else m_rxm = mask_wdata;
    end
    @(negedge clk);
    compare_all();
    ev = '0; rd_en = 0; rd_lanes = '0; mask_we = 0;
  endtask

  task automatic pump(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      ev[idx] = 1'b1;
      tick();
    end
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    model_reset();
    repeat (3) @(negedge clk);
    chk("R10 reset rx_status", rx_status, 32'h0);
    chk("R10 reset tx_status", tx_status, 32'h0);
    chk("R10 reset counters", 32'(cnt_flat), 32'h0);
    chk("R10 reset irq", 32'({rx_irq, tx_irq}), 32'h0);
    rst_n = 1'b1;

    pump(0, 31);
    ev[0] = 1; rd_en = 1; rd_sel = 3'd0; rd_lanes = 4'b0001;
    tick();
    chk("R5 set beats clear", 32'(rx_status[17]), 32'h1);
    rd_en = 1; rd_sel = 3'd0; rd_lanes = 4'b1110;
    tick();
    chk("R4 upper lanes keep flag", 32'(rx_status[17]), 32'h1);
    rd_en = 1; rd_sel = 3'd1; rd_lanes = 4'b1111;
    tick();
    chk("R4 other counter keeps flag", 32'(rx_status[17]), 32'h1);
    rd_en = 1; rd_sel = 3'd0; rd_lanes = 4'b0001;
    tick();
    chk("R3 lane0 read clears", 32'(rx_status[17]), 32'h0);
    pump(0, 5);
    chk("R7 no re-set with MSB high", 32'(rx_status[17]), 32'h0);
    chk("R7 no irq after clear", 32'(rx_irq), 32'h0);

    pump(3, 32);
    chk("R2 tx good bit 21", tx_status, 32'h0020_0000);
    tick();
    chk("R9 tx irq one cycle later", 32'(tx_irq), 32'h1);
    pump(3, 32);
    chk("R6 wrap to zero", 32'(cnt_flat[3*W +: W]), 32'h0);
    chk("R6 wrap keeps flag", 32'(tx_status[21]), 32'h1);
    mask_we = 1; mask_sel = 1; mask_wdata = 32'h0020_0000;
    tick();
    tick();
    chk("R8 masked irq low", 32'(tx_irq), 32'h0);
    chk("R8 masked status still set", 32'(tx_status[21]), 32'h1);

    for (int n = 0; n < 4000; n++) begin
      ev = 6'($urandom & $urandom);
      if ($urandom_range(0, 7) == 0) begin
        rd_en = 1; rd_sel = 3'($urandom_range(0, 5)); rd_lanes = 4'($urandom);
      end
      if ($urandom_range(0, 63) == 0) begin
        mask_we = 1; mask_sel = 1'($urandom); mask_wdata = $urandom;
      end
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule